// File: doc/BRIEF.md
# Keyed-Window Configuration Port Decoder

This block sits on a host I/O bus and turns port accesses into configuration requests using the older keyed, windowed scheme. Two byte registers live in one I/O dword: a key/function register at port 0x0CF8 and a bus-select register at port 0x0CFA. Software first writes a nonzero value into the key register, with the function number in bits 3:1. It then writes the target bus number into the bus-select register. From that point, any access to ports 0xC000 through 0xCFFF becomes a configuration request. Address bits 11:8 of the access give the device number (0 to 15), and bits 7:0 give the register offset.

The host cycle is held until it completes. A configuration request stays raised on a request/acknowledge interface until the target acknowledges it. The read data from the target goes back to the host unchanged. If no acknowledge comes within a parameterised number of cycles, the host cycle completes with all-ones read data. While the key register is zero, accesses to the window are not claimed, so the surrounding fabric can route them as ordinary I/O. Any other address is also not claimed.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the key and bus-select registers read 0x00, and neither `cfgReq` nor `ioDone` is asserted.
- R2: A write with byte lane 0 enabled at dword 0x0CF8 loads the key register from `ioWdata[7:0]`. A write with lane 2 enabled loads the bus-select register from `ioWdata[23:16]`. A read of that dword returns `{8'h00, busSel, 8'h00, key}`, and the access is claimed. Writing zero to both registers makes both read back as zero.
- R3: While the key register is nonzero, an access to ports 0xC000–0xCFFF raises `cfgReq` with the following fields: `cfgBus` = bus-select register, `cfgDev` = address bits 11:8, `cfgFunc` = key bits 3:1, `cfgReg` = address bits 7:2, and `cfgWrite` = the access direction.
- R4: While the key register is zero, a window access produces no `cfgReq`. It completes with `ioClaimed` low.
- R5: `cfgBe` is derived from address bits 1:0 and `ioSize` (0 byte, 1 word, 2 or 3 dword). For a byte access it is 1 shifted left by the offset. For a word access it is 3 shifted left by the offset, truncated to 4 bits. For a dword access it is 4'hF.
- R6: An acknowledged configuration read returns `cfgRdata` on `ioRdata`. A configuration write presents `ioWdata` on `cfgWdata`.
- R7: If a configuration request is still unacknowledged after TIMEOUT_CYCLES cycles, the host cycle completes claimed, with `ioRdata` = 0xFFFFFFFF.
- R8: An acknowledge in the same cycle that the timeout expires takes priority: the read returns `cfgRdata`.
- R9: `cfgReq` and its fields hold steady until acknowledged. `ioDone` is a single-cycle pulse in the cycle after completion. The host drops `ioReq` in that cycle.
- R10: An access outside the register dword and the window is not claimed, returns 0xFFFFFFFF and changes no register.
- R11: The window is gated by the whole key register being nonzero, not by its top nibble alone. A key of 0x02 maps the window with function 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioReq | input | 1 | Host I/O cycle pending, held until `ioDone` |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 16 | I/O port address |
| ioSize | input | 2 | 0 byte, 1 word, 2/3 dword |
| ioWdata | input | 32 | Lane-aligned write data |
| ioRdata | output | 32 | Lane-aligned read data, valid with `ioDone` |
| ioClaimed | output | 1 | Access decoded by this block, valid with `ioDone` |
| ioDone | output | 1 | One-cycle completion pulse |
| cfgReq | output | 1 | Configuration request, held until `cfgAck` |
| cfgWrite | output | 1 | Configuration direction |
| cfgBus | output | 8 | Target bus |
| cfgDev | output | 4 | Target device |
| cfgFunc | output | 3 | Target function |
| cfgReg | output | 6 | Dword register index |
| cfgBe | output | 4 | Byte enables |
| cfgWdata | output | 32 | Configuration write data |
| cfgAck | input | 1 | Target response, one cycle |
| cfgRdata | input | 32 | Target read data, valid with `cfgAck` |

## Verification
Two events can fall in the same cycle: the target's acknowledge and the expiry of the response timeout. The bench raises `cfgAck` exactly in the last waiting cycle, so both events occur together. It then checks that the target's data, not all ones, reaches the host. Acknowledges one cycle earlier are also tried, as is no acknowledge at all, so the boundary is checked from both sides. A behavioural model tracks the handshake every clock.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ctrlState_t;

  typedef struct packed {
    logic accept;
    logic regWrite;
    logic respFromCfg;
    logic respOnes;
  } ctrlStrobe_t;

  function automatic logic [3:0] laneMask(input logic [1:0] offset, input logic [1:0] size);
    logic [6:0] wide;
    case (size)
      2'd0:    wide = 7'b0000001;
      2'd1:    wide = 7'b0000011;
      default: wide = 7'b0001111;
    endcase
    if (size >= 2'd2) return 4'hF;
    wide = wide << offset;
    return wide[3:0];
  endfunction

endpackage

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioReq,
  input  logic        ioWrite,
  input  logic        hitRegs,
  input  logic        hitCfg,
  input  logic        cfgAck,
  output ctrlStrobe_t strb,
  output logic        cfgReq,
  output logic        ioDone
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT_CYCLES - 1);

  ctrlState_t state, stateNext;
  logic [CNT_W-1:0] waitCnt;
  logic expire;

  assign expire = (state == ST_WAIT) && !cfgAck && (waitCnt == LAST_WAIT);

  always_comb begin
    strb.accept      = (state == ST_IDLE) && ioReq;
    strb.regWrite    = strb.accept && hitRegs && ioWrite;
    strb.respFromCfg = (state == ST_WAIT) && cfgAck;
    strb.respOnes    = expire;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (ioReq) stateNext = hitCfg ? ST_WAIT : ST_DONE;
      ST_WAIT: if (cfgAck || expire) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

  assign cfgReq = (state == ST_WAIT);
  assign ioDone = (state == ST_DONE);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ioDone |=> !ioDone);

  // R9: an unacknowledged request before expiry stays raised
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck && waitCnt != LAST_WAIT) |=> cfgReq);

  // R7: waiting never outlasts the timeout window
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && !cfgAck && waitCnt == LAST_WAIT) |=> (ioDone && !cfgReq));

endmodule

// File: rtl/cfgwin_dpath.sv
module cfgwin_dpath
  import cfgwin_pkg::*;
#(
  parameter logic [15:0] KEY_PORT   = 16'h0CF8,
  parameter logic [15:0] BUS_PORT   = 16'h0CFA,
  parameter logic [3:0]  WIN_NIBBLE = 4'hC,
  parameter int          DEV_W      = 4,
  parameter int          REG_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              ioWrite,
  input  logic [15:0]       ioAddr,
  input  logic [1:0]        ioSize,
  input  logic [31:0]       ioWdata,
  input  logic [31:0]       cfgRdata,
  output logic              hitRegs,
  output logic              hitWin,
  output logic              hitCfg,
  output logic              keyLive,
  output logic [31:0]       ioRdata,
  output logic              ioClaimed,
  output logic              cfgWrite,
  output logic [7:0]        cfgBus,
  output logic [DEV_W-1:0]  cfgDev,
  output logic [2:0]        cfgFunc,
  output logic [REG_W-1:0]  cfgReg,
  output logic [3:0]        cfgBe,
  output logic [31:0]       cfgWdata
);

  localparam int KEY_LANE = int'(KEY_PORT[1:0]);
  localparam int BUS_LANE = int'(BUS_PORT[1:0]);
  localparam int DEV_LO   = 8;

  logic [7:0]  keyReg, busReg;
  logic [3:0]  beNow;
  logic [31:0] regWord;
  logic [31:0] respData;
  logic        claimReg;

  assign beNow   = laneMask(ioAddr[1:0], ioSize);
  assign hitRegs = (ioAddr[15:2] == KEY_PORT[15:2]);
  assign hitWin  = (ioAddr[15:12] == WIN_NIBBLE);
  assign keyLive = (keyReg != 8'h00);
  assign hitCfg  = hitWin && keyLive;

  always_comb begin
    regWord = '0;
    regWord[8*KEY_LANE +: 8] = keyReg;
    regWord[8*BUS_LANE +: 8] = busReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= 8'h00;
      busReg <= 8'h00;
    end else if (strb.regWrite) begin
      if (beNow[KEY_LANE]) keyReg <= ioWdata[8*KEY_LANE +: 8];
      if (beNow[BUS_LANE]) busReg <= ioWdata[8*BUS_LANE +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWrite <= 1'b0;
      cfgBus   <= '0;
      cfgDev   <= '0;
      cfgFunc  <= '0;
      cfgReg   <= '0;
      cfgBe    <= '0;
      cfgWdata <= '0;
      claimReg <= 1'b0;
      respData <= '1;
    end else begin
      if (strb.accept) begin
        cfgWrite <= ioWrite;
        cfgBus   <= busReg;
        cfgDev   <= ioAddr[DEV_LO +: DEV_W];
        cfgFunc  <= keyReg[3:1];
        cfgReg   <= ioAddr[2 +: REG_W];
        cfgBe    <= beNow;
        cfgWdata <= ioWdata;
        claimReg <= hitRegs || hitCfg;
        respData <= hitRegs ? regWord : '1;
      end
      if (strb.respFromCfg)  respData <= cfgRdata;
      else if (strb.respOnes) respData <= '1;
    end
  end

  assign ioRdata   = respData;
  assign ioClaimed = claimReg;

  // R2: register dword accesses are always claimed
  p_reg_claim_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && hitRegs) |=> ioClaimed);

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioReq,
  input  logic        ioWrite,
  input  logic [15:0] ioAddr,
  input  logic [1:0]  ioSize,
  input  logic [31:0] ioWdata,
  output logic [31:0] ioRdata,
  output logic        ioClaimed,
  output logic        ioDone,
  output logic        cfgReq,
  output logic        cfgWrite,
  output logic [7:0]  cfgBus,
  output logic [3:0]  cfgDev,
  output logic [2:0]  cfgFunc,
  output logic [5:0]  cfgReg,
  output logic [3:0]  cfgBe,
  output logic [31:0] cfgWdata,
  input  logic        cfgAck,
  input  logic [31:0] cfgRdata
);

  ctrlStrobe_t strb;
  logic hitRegs, hitWin, hitCfg, keyLive;

  cfgwin_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWrite(ioWrite),
    .hitRegs(hitRegs), .hitCfg(hitCfg), .cfgAck(cfgAck),
    .strb(strb), .cfgReq(cfgReq), .ioDone(ioDone)
  );

  cfgwin_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWdata(ioWdata), .cfgRdata(cfgRdata),
    .hitRegs(hitRegs), .hitWin(hitWin), .hitCfg(hitCfg), .keyLive(keyLive),
    .ioRdata(ioRdata), .ioClaimed(ioClaimed), .cfgWrite(cfgWrite),
    .cfgBus(cfgBus), .cfgDev(cfgDev), .cfgFunc(cfgFunc), .cfgReg(cfgReg),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata)
  );

  // R4: a window access with a zero key never reaches configuration space
  p_keyzero_no_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !cfgReq && !ioDone && hitWin && !keyLive) |=> !cfgReq);

  // R6: acknowledged read data reaches the host
  p_ack_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && cfgAck && !cfgWrite) |=> (ioDone && ioRdata == $past(cfgRdata)));

  // R5: a live request always has at least one lane enabled
  p_be_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> (cfgBe != 4'h0));

  // R9: request fields hold while the request is raised
  p_fields_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && $past(cfgReq)) |-> ($stable(cfgDev) && $stable(cfgBus) && $stable(cfgReg)));

endmodule

// File: tb/test_cfgwin_top.sv
module test_cfgwin_top;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioReq = 1'b0, ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        ioClaimed, ioDone, cfgReq, cfgWrite;
  logic [7:0]  cfgBus;
  logic [3:0]  cfgDev;
  logic [2:0]  cfgFunc;
  logic [5:0]  cfgReg;
  logic [3:0]  cfgBe;
  logic [31:0] cfgWdata;
  logic        cfgAck = 1'b0;
  logic [31:0] cfgRdata = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cfgwin_top #(.TIMEOUT_CYCLES(TMO)) i_cfgwin_top (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioSize(ioSize), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioClaimed(ioClaimed),
    .ioDone(ioDone), .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgBus(cfgBus),
    .cfgDev(cfgDev), .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .cfgAck(cfgAck), .cfgRdata(cfgRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference: state 0 idle, 1 waiting, 2 completing
  int mState = 0, mCnt = 0;
  logic [7:0] mKey = 0, mBus = 0;
  logic [31:0] mResp = '1;
  logic mClaim = 0, mWr = 0;
  logic [3:0] mDev = 0; logic [2:0] mFunc = 0; logic [5:0] mReg = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mKey = 0; mBus = 0;
    end else begin
      case (mState)
        0: if (ioReq) begin
             logic regs, win;
             logic [3:0] be;
             regs = (ioAddr[15:2] == 14'h033E);
             win  = (ioAddr[15:12] == 4'hC) && (mKey != 0);
             be = (ioSize >= 2) ? 4'hF : ((ioSize == 1) ? 4'(7'h3 << ioAddr[1:0]) : 4'(7'h1 << ioAddr[1:0]));
             mWr = ioWrite; mClaim = regs || win;
             mResp = regs ? {8'h00, mBus, 8'h00, mKey} : 32'hFFFFFFFF;
             mDev = ioAddr[11:8]; mFunc = mKey[3:1]; mReg = ioAddr[7:2];
             if (regs && ioWrite) begin
               if (be[0]) mKey = ioWdata[7:0];
               if (be[2]) mBus = ioWdata[23:16];
             end
             mCnt = 0;
             mState = win ? 1 : 2;
           end
        1: if (cfgAck) begin mResp = cfgRdata; mState = 2; end
           else if (mCnt == TMO - 1) begin mResp = 32'hFFFFFFFF; mState = 2; end
           else mCnt++;
        default: mState = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R9 model ioDone", 32'(ioDone), 32'(mState == 2));
      check("R9 model cfgReq", 32'(cfgReq), 32'(mState == 1));
      if (mState == 2) begin
        check("R4 model claim", 32'(ioClaimed), 32'(mClaim));
        if (!mWr) check("R6 model rdata", ioRdata, mResp);
      end
      if (mState == 1) begin
        check("R3 model dev", 32'(cfgDev), 32'(mDev));
        check("R3 model func", 32'(cfgFunc), 32'(mFunc));
        check("R3 model reg", 32'(cfgReg), 32'(mReg));
      end
    end
  end

  // transaction results
  logic [31:0] gRdata; logic gClaim; int gReqCycles; int gDonePulses;
  logic [7:0] gBus; logic [3:0] gDev, gBe; logic [2:0] gFunc; logic [5:0] gReg;
  logic gWrite; logic [31:0] gWdata;

  task automatic io(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                    input logic [31:0] wd, input int ackAt, input logic [31:0] ad);
    @(negedge clk);
    ioReq = 1; ioWrite = wr; ioAddr = a; ioSize = sz; ioWdata = wd;
    gReqCycles = 0; gDonePulses = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (cfgReq) begin
        if (gReqCycles == 0) begin
          gBus = cfgBus; gDev = cfgDev; gFunc = cfgFunc; gReg = cfgReg;
          gBe = cfgBe; gWrite = cfgWrite; gWdata = cfgWdata;
        end
        cfgAck = (gReqCycles == ackAt); cfgRdata = ad;
        gReqCycles++;
      end else cfgAck = 0;
      if (ioDone) begin
        gRdata = ioRdata; gClaim = ioClaimed; gDonePulses++;
        ioReq = 0; cfgAck = 0;
        break;
      end
      if (n == 199) begin
        errors++; checks++;
        $display("FAIL R9: watchdog, actual hung expected done");
      end
    end
    @(negedge clk);
    if (ioDone) gDonePulses++;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9: global watchdog expired, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cfgReq after reset", 32'(cfgReq), 0);
    check("R1 ioDone after reset", 32'(ioDone), 0);
    rstN = 1;
    io(0, 16'h0CF8, 2, 0, -1, 0);
    check("R1 regs read zero", gRdata, 32'h0);
    check("R2 reg read claimed", 32'(gClaim), 1);
    check("R9 single done pulse", 32'(gDonePulses), 1);

    // R2 byte writes
    io(1, 16'h0CF8, 0, 32'h0000_00F6, -1, 0);
    io(1, 16'h0CFA, 0, 32'h0042_0000, -1, 0);
    io(0, 16'h0CF8, 2, 0, -1, 0);
    check("R2 byte write readback", gRdata, 32'h0042_00F6);

    // R3 R5 R6 read via window, dword
    io(0, 16'hC5A4, 2, 0, 0, 32'hDEAD_BEEF);
    check("R3 bus", 32'(gBus), 32'h42);
    check("R3 dev", 32'(gDev), 5);
    check("R3 func", 32'(gFunc), 3);
    check("R3 reg", 32'(gReg), 32'h29);
    check("R3 direction", 32'(gWrite), 0);
    check("R6 read data", gRdata, 32'hDEAD_BEEF);
    check("R5 dword be", 32'(gBe), 32'hF);

    // R6 write, R5 byte lane 3, R9 held request
    io(1, 16'hCF13, 0, 32'h7700_0000, 3, 0);
    check("R6 write data", gWdata, 32'h7700_0000);
    check("R5 byte be", 32'(gBe), 32'h8);
    check("R9 req held until ack", 32'(gReqCycles), 4);
    check("R3 write direction", 32'(gWrite), 1);

    io(0, 16'hC002, 1, 0, 0, 32'h1234_5678);
    check("R5 word be", 32'(gBe), 32'hC);
    io(0, 16'hC003, 1, 0, 0, 32'h1234_5678);
    check("R5 word truncated be", 32'(gBe), 32'h8);

    // R7 timeout
    io(0, 16'hC100, 2, 0, -1, 32'h5555_5555);
    check("R7 timeout data", gRdata, 32'hFFFF_FFFF);
    check("R7 timeout claimed", 32'(gClaim), 1);
    check("R7 wait length", 32'(gReqCycles), TMO);

    // R8 ack at expiry wins; one earlier too
    io(0, 16'hC100, 2, 0, TMO - 1, 32'hA5A5_0001);
    check("R8 ack at expiry wins", gRdata, 32'hA5A5_0001);
    io(0, 16'hC100, 2, 0, TMO - 2, 32'hA5A5_0002);
    check("R8 ack before expiry", gRdata, 32'hA5A5_0002);

    // R10 other address
    io(1, 16'h0CFC, 2, 32'hFFFF_FFFF, -1, 0);
    check("R10 other unclaimed", 32'(gClaim), 0);
    io(0, 16'h0080, 0, 0, -1, 0);
    check("R10 other reads ones", gRdata, 32'hFFFF_FFFF);
    io(0, 16'h0CF8, 2, 0, -1, 0);
    check("R10 regs untouched", gRdata, 32'h0042_00F6);

    // R11 key without top nibble still maps
    io(1, 16'h0CF8, 2, 32'h0007_0002, -1, 0);
    io(0, 16'hCF00, 2, 0, 0, 32'h0BAD_F00D);
    check("R11 func from low key", 32'(gFunc), 1);
    check("R11 bus from dword write", 32'(gBus), 7);
    check("R11 mapped", 32'(gClaim), 1);

    // R2 zero both, R4 key zero gating
    io(1, 16'h0CF8, 0, 32'h0, -1, 0);
    io(1, 16'h0CFA, 0, 32'h0, -1, 0);
    io(0, 16'h0CF8, 2, 0, -1, 0);
    check("R2 zeroed readback", gRdata, 32'h0);
    io(0, 16'hC300, 2, 0, 0, 32'h1111_1111);
    check("R4 no request", 32'(gReqCycles), 0);
    check("R4 unclaimed", 32'(gClaim), 0);
    check("R4 ones", gRdata, 32'hFFFF_FFFF);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule